// File: doc/BRIEF.md
# Frame Scanout Read Address Generator

This block walks a frame buffer held in memory and turns it into a stream of burst read requests, one line after another. Software-visible settings come in as plain inputs: the address of the first byte of the frame, the number of bytes fetched from each line, the byte distance between the starts of consecutive lines, and the number of lines minus one. Each line is cut into bursts of at most `MAX_BURST` beats of `BEAT_BYTES` bytes; a line whose beat count is not a multiple of the burst size ends with one shorter burst. Every request carries a start-of-line marker on the first burst of a line and an end-of-frame marker on the last burst of the frame.

Requests leave through a valid/ready handshake. A credit counter tracks requests in flight: it rises on every accepted request and falls on every pulse of the response-completion input. No request is offered while the count equals the programmed limit. While the run input stays high, frames repeat back to back, and the frame settings are sampled again at the start of each frame. When run is low at the end of a frame, the block goes idle.

The controller has three states. IDLE waits for run. The transition IDLE to LOAD happens when run is high. LOAD samples the settings and always moves on to FETCH. FETCH issues the bursts. At the end of a frame, FETCH goes back to LOAD when run is still high, and to IDLE when it is low.

Top module: `scan_addr_gen`

## Requirements
- R1: After reset the block is in IDLE with req_valid low, and it stays that way while run is low.
- R2: When run rises, the first request of the frame is at cfg_base. The frame base is sampled only in LOAD, so a change to cfg_base during a frame has no effect on that frame's addresses.
- R3: The beat count of a line is the line byte count divided by BEAT_BYTES (8), rounded up. req_beats gives the beat count of the burst as a plain number from 1 to MAX_BURST (16). Each line is fetched as full 16-beat bursts, followed by one shorter burst if a remainder is left.
- R4: Within a line, each burst's address is the previous burst's address plus the previous burst's beats times BEAT_BYTES.
- R5: Line n of a frame starts at frame base plus n times cfg_pitch, whatever the line byte count is.
- R6: A frame holds exactly cfg_lines_m1 + 1 lines.
- R7: req_sol is high only on the first burst of each line. req_eof is high only on the last burst of the last line.
- R8: req_valid is low whenever the number of accepted requests minus the number of rsp_done pulses equals cfg_max_out. Each rsp_done pulse frees one credit.
- R9: While req_valid is high and req_ready is low, the request stays offered with unchanged address, beat count and markers.
- R10: After the end-of-frame burst is accepted, the block starts a new frame from a freshly sampled cfg_base if run is high. If run is low, it goes idle and offers no further requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Keep scanning frames while high |
| cfg_base | input | ADDR_W | Address of the first byte of the frame |
| cfg_line_bytes | input | LEN_W | Bytes fetched per line (at least 1) |
| cfg_pitch | input | ADDR_W | Byte distance between line starts |
| cfg_lines_m1 | input | CNT_W | Number of lines minus one |
| cfg_max_out | input | OUT_W | Limit on requests in flight (at least 1) |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted when high together with req_valid |
| req_addr | output | ADDR_W | Burst start address |
| req_beats | output | $clog2(MAX_BURST)+1 | Beats in this burst, 1 to MAX_BURST |
| req_sol | output | 1 | First burst of a line |
| req_eof | output | 1 | Last burst of the frame |
| rsp_done | input | 1 | One outstanding request completed |

## Verification
The assertions assume that rsp_done never pulses while no request is outstanding, that cfg_max_out is at least one and does not change while requests are in flight, and that the line byte count is non-zero. The stimulus meets these conditions in the following way. The bench keeps its own count of outstanding requests and only drives a completion when that count is positive. It resets the block before each new configuration, and it uses only non-zero line lengths. Within those limits, the bench varies ready throttling, completion rate, remainder bursts and mid-frame base changes.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_FETCH = 2'd2
    } scan_state_e;
endpackage

// File: rtl/scan_burst_split.sv
module scan_burst_split #(
    parameter int LEN_W     = 16,
    parameter int MAX_BURST = 16,
    parameter int BL_W      = $clog2(MAX_BURST) + 1
) (
    input  logic [LEN_W-1:0] rem_beats,
    output logic [BL_W-1:0]  burst_beats,
    output logic             line_last
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_BURST);

    always_comb begin
        line_last   = (rem_beats <= CAP);
        burst_beats = line_last ? BL_W'(rem_beats) : BL_W'(MAX_BURST);
    end
endmodule

// File: rtl/scan_credit.sv
module scan_credit #(
    parameter int OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             give,
    input  logic [OUT_W-1:0] limit,
    output logic [OUT_W-1:0] count,
    output logic             avail
);
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + OUT_W'(take) - OUT_W'(give);
    end

    assign avail = (count < limit);

    // R8: the in-flight count never passes the programmed limit
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= limit);

    // R8: a completion only arrives for a request that is in flight
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !give);
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
    import scan_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int CNT_W      = 12,
    parameter int OUT_W      = 4,
    parameter int BEAT_BYTES = 8,
    parameter int MAX_BURST  = 16,
    localparam int BL_W      = $clog2(MAX_BURST) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_line_bytes,
    input  logic [ADDR_W-1:0] cfg_pitch,
    input  logic [CNT_W-1:0]  cfg_lines_m1,
    input  logic [OUT_W-1:0]  cfg_max_out,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BL_W-1:0]   req_beats,
    output logic              req_sol,
    output logic              req_eof,
    input  logic              rsp_done
);
    localparam int BSH = $clog2(BEAT_BYTES);

    scan_state_e state_q, state_d;

    logic [ADDR_W-1:0] line_addr_q, burst_addr_q, pitch_q;
    logic [LEN_W-1:0]  rem_q, beats_q;
    logic [CNT_W-1:0]  lines_m1_q, line_idx_q;

    logic [LEN_W:0]    bytes_round;
    logic [LEN_W-1:0]  beats_in;
    logic [BL_W-1:0]   burst_beats;
    logic              line_last, last_line, fire, credit_ok;
    logic [OUT_W-1:0]  in_flight;
    logic [ADDR_W-1:0] burst_bytes, next_line;

    assign bytes_round = {1'b0, cfg_line_bytes} + (LEN_W+1)'(BEAT_BYTES - 1);
    assign beats_in    = LEN_W'(bytes_round >> BSH);
    assign burst_bytes = ADDR_W'(burst_beats) << BSH;
    assign next_line   = line_addr_q + pitch_q;
    assign last_line   = (line_idx_q == lines_m1_q);
    assign fire        = req_valid && req_ready;

    scan_burst_split #(.LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .BL_W(BL_W)) u_split (
        .rem_beats   (rem_q),
        .burst_beats (burst_beats),
        .line_last   (line_last)
    );

    scan_credit #(.OUT_W(OUT_W)) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (fire),
        .give  (rsp_done),
        .limit (cfg_max_out),
        .count (in_flight),
        .avail (credit_ok)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_FETCH;
            ST_FETCH: if (fire && line_last && last_line)
                          state_d = run ? ST_LOAD : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // address datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_addr_q  <= '0;
            burst_addr_q <= '0;
            pitch_q      <= '0;
            rem_q        <= '0;
            beats_q      <= '0;
            lines_m1_q   <= '0;
            line_idx_q   <= '0;
        end else if (state_q == ST_LOAD) begin
            line_addr_q  <= cfg_base;
            burst_addr_q <= cfg_base;
            pitch_q      <= cfg_pitch;
            rem_q        <= beats_in;
            beats_q      <= beats_in;
            lines_m1_q   <= cfg_lines_m1;
            line_idx_q   <= '0;
        end else if (state_q == ST_FETCH && fire) begin
            if (!line_last) begin
                burst_addr_q <= burst_addr_q + burst_bytes;
                rem_q        <= rem_q - LEN_W'(burst_beats);
            end else if (!last_line) begin
                line_addr_q  <= next_line;
                burst_addr_q <= next_line;
                rem_q        <= beats_q;
                line_idx_q   <= line_idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req_valid = (state_q == ST_FETCH) && credit_ok;
        req_addr  = burst_addr_q;
        req_beats = burst_beats;
        req_sol   = (rem_q == beats_q);
        req_eof   = last_line && line_last;
    end

    // R8: no request offered while the credits are used up
    p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flight == cfg_max_out) |-> !req_valid);

    // R9: a stalled request holds its contents
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                       $stable(req_beats) && $stable(req_sol) &&
                                       $stable(req_eof)));

    // R3: burst beat count within 1..MAX_BURST
    p_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_beats != '0 && req_beats <= BL_W'(MAX_BURST)));

    // R10: final burst with run low leads to idle
    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_eof && !run) |=> (state_q == ST_IDLE && !req_valid));

    // R1: requests only come from the fetching state
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FETCH) |-> !req_valid);
endmodule

// File: tb/tb_scan_addr_gen.sv
`timescale 1ns/1ps
module tb_scan_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n, run, req_ready, rsp_done;
    logic [31:0] cfg_base, cfg_pitch, req_addr;
    logic [15:0] cfg_line_bytes;
    logic [11:0] cfg_lines_m1;
    logic [3:0]  cfg_max_out;
    logic        req_valid, req_sol, req_eof;
    logic [4:0]  req_beats;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    scan_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_base(cfg_base),
        .cfg_line_bytes(cfg_line_bytes), .cfg_pitch(cfg_pitch),
        .cfg_lines_m1(cfg_lines_m1), .cfg_max_out(cfg_max_out),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_beats(req_beats), .req_sol(req_sol), .req_eof(req_eof),
        .rsp_done(rsp_done)
    );

    // stimulus table: base, line bytes, pitch, lines-1, limit, slow responses, toggled ready
    localparam int NV = 5;
    localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h2000_0000, 32'h0000_0400, 32'h0010_0000, 32'h0000_8000};
    localparam int V_LEN   [NV] = '{256, 200, 20, 128, 8};
    localparam int V_PITCH [NV] = '{256, 512, 64, 4096, 8};
    localparam int V_LM1   [NV] = '{2, 1, 0, 3, 5};
    localparam int V_LIM   [NV] = '{15, 2, 1, 4, 7};
    localparam bit V_SLOW  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam bit V_TOG   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run = 1'b0; req_ready = 1'b0; rsp_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_frames(input int len, input int pitch, input int lm1, input int lim,
                              input int nfr, input logic [31:0] b0, input logic [31:0] b1,
                              input bit slow, input bit tog);
        int beats_line = (len + 7) / 8;
        int line = 0, off = 0, frame = 0, pend = 0, cyc = 0, nreq = 0;
        bit done = 0, held = 0, first = 1;
        logic [31:0] haddr, fb, ea;
        logic [4:0]  hbeats;
        int rb, eb;
        bit rsp, rdy;
        cfg_base = b0; cfg_line_bytes = 16'(len); cfg_pitch = 32'(pitch);
        cfg_lines_m1 = 12'(lm1); cfg_max_out = 4'(lim);
        run = 1'b1;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (pend >= lim) chk(!req_valid, "R8", "valid at limit", req_valid, 0);
            if (held) begin
                chk(req_valid && req_addr == haddr && req_beats == hbeats, "R9",
                    "stalled request", req_addr, haddr);
                held = 0;
            end
            rsp = (pend > 0) && (!slow || cyc % 4 == 0);
            rdy = !tog || (cyc % 2 == 0);
            if (req_valid && rdy) begin
                fb = (frame == 0) ? b0 : b1;
                rb = beats_line - off;
                eb = (rb > 16) ? 16 : rb;
                ea = fb + 32'(line * pitch) + 32'(off * 8);
                if (line == 0 && off == 0)
                    chk(req_addr == ea, "R2", "frame start addr", req_addr, ea);
                else if (off == 0)
                    chk(req_addr == ea, "R5", "line start addr", req_addr, ea);
                else
                    chk(req_addr == ea, "R4", "burst addr", req_addr, ea);
                chk(req_beats == 5'(eb), "R3", "burst beats", req_beats, eb);
                chk(req_sol == (off == 0), "R7", "sol marker", req_sol, off == 0);
                chk(req_eof == (line == lm1 && rb == eb), "R7", "eof marker",
                    req_eof, line == lm1 && rb == eb);
                nreq++;
                if (first && nfr > 1) cfg_base = b1;
                if (frame == nfr - 1) run = 1'b0;
                first = 0;
                off += eb;
                if (off == beats_line) begin
                    off = 0;
                    if (line == lm1) begin
                        line = 0; frame++;
                        if (frame == nfr) done = 1;
                    end else line++;
                end
            end else if (req_valid) begin
                held = 1; haddr = req_addr; hbeats = req_beats;
            end
            pend = pend - int'(rsp) + int'(req_valid && rdy);
            rsp_done = rsp; req_ready = rdy;
        end
        chk(done, "R6", "frames completed", frame, nfr);
        req_ready = 1'b1;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            chk(!req_valid, "R10", "idle after final frame", req_valid, 0);
            rsp_done = (pend > 0);
            if (pend > 0) pend--;
        end
        rsp_done = 1'b0; req_ready = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int acc;
        cfg_base = '0; cfg_line_bytes = 16'd8; cfg_pitch = '0;
        cfg_lines_m1 = '0; cfg_max_out = 4'd1;
        do_reset();
        // R1: reset state, run low
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(!req_valid, "R1", "valid after reset", req_valid, 0);
        end

        // vector table
        for (int v = 0; v < NV; v++) begin
            do_reset();
            run_frames(V_LEN[v], V_PITCH[v], V_LM1[v], V_LIM[v], 1,
                       V_BASE[v], V_BASE[v], V_SLOW[v], V_TOG[v]);
        end

        // R2 / R10: base changed mid-frame, used only by the next frame
        do_reset();
        run_frames(16, 32, 1, 4, 2, 32'h0000_4000, 32'h0000_9000, 1'b0, 1'b0);

        // R8: credit limit with responses withheld
        do_reset();
        cfg_base = 32'h0000_2000; cfg_line_bytes = 16'd1024; cfg_pitch = 32'd1024;
        cfg_lines_m1 = '0; cfg_max_out = 4'd3;
        run = 1'b1; req_ready = 1'b1;
        acc = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (req_valid) acc++;
        end
        chk(acc == 3, "R8", "accepted before limit", acc, 3);
        chk(!req_valid, "R8", "valid at limit", req_valid, 0);
        rsp_done = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0;
        chk(req_valid, "R8", "valid after one completion", req_valid, 1);
        chk(req_addr == 32'h0000_2000 + 32'd384, "R4", "fourth burst addr",
            req_addr, 32'h0000_2000 + 32'd384);
        @(negedge clk);
        chk(!req_valid, "R8", "valid at limit again", req_valid, 0);

        do_reset();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule